// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Signed Overflow

This block adds or subtracts two two's-complement operands of a parameterised width. A single mode input picks the operation. Addition computes A + B. Subtraction computes A + ~B + 1, so one carry network serves both operations.

The carry logic has two levels. Each 4-bit group works out its own internal carries directly from per-bit generate and propagate terms. Each group also reports a group generate and a group propagate. A second lookahead stage uses those to compute the carry entering every group. No stage waits for a carry to ripple through the stages below it.

The registered outputs are the result, the raw carry out of the top bit, and a signed-overflow flag. The overflow flag is the XOR of the carry into the sign bit and the carry out of it. Results appear one clock after the operands are presented.

Top module: `lookahead_addsub`

## Requirements
- R1: While reset is high at a rising edge, the result, carry and overflow outputs are all 0 after that edge.
- R2: With the mode bit at 0, the outputs after the next edge hold the sum A + B. The result is its low WIDTH bits and the carry is bit WIDTH.
- R3: With the mode bit at 1, the outputs after the next edge hold A + ~B + 1. The result is its low WIDTH bits. The carry is 1 exactly when A is greater than or equal to B as unsigned numbers, meaning no borrow.
- R4: In add mode, overflow is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R5: In subtract mode, overflow is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R6: A carry born in bit 0 crosses every group boundary. All-ones plus one gives result 0, carry 1 and overflow 0. An operand with ones in every group except the top, plus one, gives the next power of two with carry 0.
- R7: Subtracting a value from itself gives 0 with carry 1 and overflow 0. Zero minus one gives all ones with carry 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_a | input | WIDTH | First operand |
| i_b | input | WIDTH | Second operand |
| i_sub | input | 1 | Mode: 0 add, 1 subtract |
| o_result | output | WIDTH | Registered sum or difference |
| o_carry | output | 1 | Registered carry out of the top bit (1 = no borrow when subtracting) |
| o_ovf | output | 1 | Registered signed-overflow flag |

## Verification
The bench crosses zero, one, the largest positive value, the most negative value and minus one in both modes. Those pairs are where a wrong overflow rule shows up: a flag taken from the raw carry out, or one that ignores the inverted B, would misreport most-negative minus one or zero minus most-negative. A carry chain that loses the injected carry-in, or drops a term in a group or in the second level, would corrupt all-ones plus one and the cross-group operands. Borrow polarity is checked through A minus A and zero minus one. Random operands in both modes cover the remaining carry paths.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int GRP_W = 4;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic g_o,
  output logic p_o,
  output logic s_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;
  assign s_o = p_o ^ c_i;
endmodule

// File: rtl/cla_group4.sv
module cla_group4
  import addsub_pkg::*;
(
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             c_in,
  output logic [GRP_W-1:0] sum_o,
  output gp_t              grp_o,
  output logic             c_top_o
);
  logic [GRP_W-1:0] g_v;
  logic [GRP_W-1:0] p_v;
  logic [GRP_W-1:0] cin_v;

  for (genvar k = 0; k < GRP_W; k++) begin : g_cell
    cla_bit_cell u_cell (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (cin_v[k]),
      .g_o (g_v[k]),
      .p_o (p_v[k]),
      .s_o (sum_o[k])
    );
  end

  // Flattened two-level carries; none is derived from another carry.
  always_comb begin
    cin_v[0] = c_in;
    cin_v[1] = g_v[0] | (p_v[0] & c_in);
    cin_v[2] = g_v[1] | (p_v[1] & g_v[0]) | (p_v[1] & p_v[0] & c_in);
    cin_v[3] = g_v[2] | (p_v[2] & g_v[1]) | (p_v[2] & p_v[1] & g_v[0])
             | (p_v[2] & p_v[1] & p_v[0] & c_in);
  end

  assign grp_o.g = g_v[3] | (p_v[3] & g_v[2]) | (p_v[3] & p_v[2] & g_v[1])
                 | (p_v[3] & p_v[2] & p_v[1] & g_v[0]);
  assign grp_o.p = &p_v;
  assign c_top_o = cin_v[3];
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry #(
  parameter int GROUPS = 4
) (
  input  logic [GROUPS-1:0] gg_i,
  input  logic [GROUPS-1:0] gp_i,
  input  logic              c_in,
  output logic [GROUPS:0]   c_o
);
  // Each group carry is an OR of AND terms over the group G/P and c_in.
  always_comb begin
    logic acc;
    logic term;
    c_o[0] = c_in;
    for (int j = 0; j < GROUPS; j++) begin
      acc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        term = gg_i[k];
        for (int m = k + 1; m <= j; m++) term = term & gp_i[m];
        acc = acc | term;
      end
      term = c_in;
      for (int m = 0; m <= j; m++) term = term & gp_i[m];
      c_o[j+1] = acc | term;
    end
  end
endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] i_a,
  input  logic [WIDTH-1:0] i_b,
  input  logic             i_sub,
  output logic [WIDTH-1:0] o_result,
  output logic             o_carry,
  output logic             o_ovf
);
  localparam int GROUPS = WIDTH / GRP_W;

  if ((WIDTH % GRP_W) != 0 || WIDTH < GRP_W) begin : g_width_bad
    $error("lookahead_addsub: WIDTH must be a nonzero multiple of 4");
  end

  logic [WIDTH-1:0]  b_eff;
  logic [WIDTH-1:0]  sum_c;
  logic [GROUPS-1:0] grp_g;
  logic [GROUPS-1:0] grp_p;
  logic [GROUPS-1:0] grp_top;
  logic [GROUPS:0]   grp_c;

  assign b_eff = i_sub ? ~i_b : i_b;

  for (genvar q = 0; q < GROUPS; q++) begin : g_grp
    gp_t gp_w;
    cla_group4 u_grp (
      .a_i     (i_a[q*GRP_W +: GRP_W]),
      .b_i     (b_eff[q*GRP_W +: GRP_W]),
      .c_in    (grp_c[q]),
      .sum_o   (sum_c[q*GRP_W +: GRP_W]),
      .grp_o   (gp_w),
      .c_top_o (grp_top[q])
    );
    assign grp_g[q] = gp_w.g;
    assign grp_p[q] = gp_w.p;
  end

  cla_group_carry #(.GROUPS(GROUPS)) u_carry (
    .gg_i (grp_g),
    .gp_i (grp_p),
    .c_in (i_sub),
    .c_o  (grp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_result <= '0;
      o_carry  <= 1'b0;
      o_ovf    <= 1'b0;
    end else begin
      o_result <= sum_c;
      o_carry  <= grp_c[GROUPS];
      o_ovf    <= grp_c[GROUPS] ^ grp_top[GROUPS-1];
    end
  end
endmodule

// File: rtl/lookahead_addsub_chk.sv
module lookahead_addsub_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] i_a,
  input logic [WIDTH-1:0] i_b,
  input logic             i_sub,
  input logic [WIDTH-1:0] o_result,
  input logic             o_carry,
  input logic             o_ovf
);
  localparam logic [WIDTH:0] ONE_X = 1;
  localparam int SB = WIDTH - 1;

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst_q |-> (o_result == '0 && !o_carry && !o_ovf));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !$past(i_sub)) |->
      ({o_carry, o_result} == ({1'b0, $past(i_a)} + {1'b0, $past(i_b)})));

  // R3
  sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $past(i_sub)) |->
      ({o_carry, o_result} == ({1'b0, $past(i_a)} + {1'b0, ~$past(i_b)} + ONE_X)));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $past(i_sub)) |-> (o_carry == ($past(i_a) >= $past(i_b))));

  // R4
  add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !$past(i_sub)) |->
      (o_ovf == (($past(i_a[SB]) == $past(i_b[SB])) && (o_result[SB] != $past(i_a[SB])))));

  // R5
  sub_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && $past(i_sub)) |->
      (o_ovf == (($past(i_a[SB]) != $past(i_b[SB])) && (o_result[SB] != $past(i_a[SB])))));
endmodule

bind lookahead_addsub lookahead_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .i_a      (i_a),
  .i_b      (i_b),
  .i_sub    (i_sub),
  .o_result (o_result),
  .o_carry  (o_carry),
  .o_ovf    (o_ovf)
);

// File: tb/test_lookahead_addsub.sv
module test_lookahead_addsub;
  localparam int W = 16;
  localparam longint MOD = longint'(1) << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] i_a = '0;
  logic [W-1:0] i_b = '0;
  logic         i_sub = 1'b0;
  logic [W-1:0] o_result;
  logic         o_carry;
  logic         o_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lookahead_addsub #(.WIDTH(W)) i_lookahead_addsub (
    .clk(clk), .rst(rst), .i_a(i_a), .i_b(i_b), .i_sub(i_sub),
    .o_result(o_result), .o_carry(o_carry), .o_ovf(o_ovf)
  );

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint to_signed(input longint u);
    return (u >= MOD / 2) ? u - MOD : u;
  endfunction

  // Behavioural reference: integer arithmetic on the operands.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub, input string extra);
    longint ua, ub, full, sa, sb, tru;
    string  t_val, t_ovf;
    ua = longint'(a);
    ub = longint'(b);
    full = sub ? ua + (MOD - 1 - ub) + 1 : ua + ub;
    sa = to_signed(ua);
    sb = to_signed(ub);
    tru = sub ? sa - sb : sa + sb;
    t_val = sub ? "R3" : "R2";
    t_ovf = sub ? "R5" : "R4";
    if (extra != "") begin
      t_val = {extra, "/", t_val};
      t_ovf = {extra, "/", t_ovf};
    end
    @(negedge clk);
    i_a = a; i_b = b; i_sub = sub;
    @(negedge clk);
    cmp(t_val, "result", longint'(o_result), full % MOD);
    cmp(t_val, "carry", longint'(o_carry), full / MOD);
    if (sub) cmp("R3", "no-borrow", longint'(o_carry), longint'(ua >= ub));
    cmp(t_ovf, "overflow", longint'(o_ovf), longint'(tru >= MOD / 2 || tru < -(MOD / 2)));
  endtask

  initial begin
    logic [W-1:0] corner [5];
    corner[0] = '0;
    corner[1] = 1;
    corner[2] = {1'b0, {(W-1){1'b1}}};
    corner[3] = {1'b1, {(W-1){1'b0}}};
    corner[4] = '1;

    repeat (3) @(negedge clk);
    cmp("R1", "reset result", longint'(o_result), 0);
    cmp("R1", "reset carry", longint'(o_carry), 0);
    cmp("R1", "reset ovf", longint'(o_ovf), 0);
    rst = 1'b0;

    // R6: carry crossing every group
    run('1, 1, 1'b0, "R6");
    run({4'h0, {(W-4){1'b1}}}, 1, 1'b0, "R6");
    run(16'h0FFF, 16'h0001, 1'b0, "R6");
    // R7: self-subtraction and borrow from zero
    run(16'h1234, 16'h1234, 1'b1, "R7");
    run('0, 1, 1'b1, "R7");
    // R4/R5 explicit overflow corners
    run(corner[2], 1, 1'b0, "R4");
    run(corner[3], corner[4], 1'b0, "R4");
    run(corner[3], 1, 1'b1, "R5");
    run('0, corner[3], 1'b1, "R5");

    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          run(corner[x], corner[y], s[0], "");

    for (int n = 0; n < 400; n++)
      run(W'($urandom), W'($urandom), 1'($urandom), "");

    // R1: reset during operation clears the outputs
    @(negedge clk);
    i_a = 16'h7FFF; i_b = 16'h7FFF; i_sub = 1'b0; rst = 1'b1;
    @(negedge clk);
    cmp("R1", "mid reset result", longint'(o_result), 0);
    cmp("R1", "mid reset carry", longint'(o_carry), 0);
    cmp("R1", "mid reset ovf", longint'(o_ovf), 0);
    rst = 1'b0;
    run(16'h7FFF, 16'h7FFF, 1'b0, "R4");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule